// File: doc/BRIEF.md
# Interrupt and System Register Unit

This block sits in the memory stage of a pipelined processor and holds its system state. That state is a status word, a handler address, a return address and a cause register. The status word has four bits: interrupt enable, saved interrupt enable, current mode and saved mode. In every cycle a single combinational chain works out the next values of these registers. The chain first applies the memory-stage instruction (a system-register write or a return-from-interrupt). It then applies an illegal-instruction trap flagged from the ALU stage. Last, it applies a device interrupt. Each step works on the values left by the step before it, and the registers take the final result on the clock edge.

When a trap or interrupt is taken, the unit raises a take signal that the pipeline uses to flush its front stages. It also supplies the handler address to redirect fetch to. A separate combinational read port serves the read-system-register instruction and returns the values held at the start of the cycle.

Top module: `sru_top`

## Requirements
- R1: Each cycle the instruction step runs first and the trap steps see its results. A status write that sets interrupt enable, made while a request is pending and the slot holds no bubble, causes the interrupt in that same cycle. A return-from-interrupt that clears interrupt enable blocks a request in that same cycle.
- R2: A return-from-interrupt sets interrupt enable to the saved interrupt enable and sets current mode to saved mode. The saved bits are left unchanged.
- R3: Register indices are 0 for status, 1 for handler, 2 for return address and 3 for cause. A write to status loads {saved mode, current mode, saved IE, IE} from bits [3:0] of the write data. Writes to handler or return address load the full word. A write to cause has no effect.
- R4: A device interrupt is taken only when three conditions hold: interrupt enable is 1 after the earlier steps, a request is pending, and the memory-stage slot is not a bubble.
- R5: Taking a device interrupt copies interrupt enable into saved IE and clears interrupt enable. It copies current mode into saved mode and sets current mode to 1. It stores the memory-stage instruction's own next PC as the return address and the zero-extended device number as the cause.
- R6: An illegal-instruction flag is taken whatever the value of interrupt enable. It makes the same status and return-address changes as R5 and stores the cause code 0x00000100. Because it clears interrupt enable, it blocks a device interrupt in the same cycle.
- R7: The read port returns the register values from the start of the cycle. A status read gives {saved mode, current mode, saved IE, IE} in bits [3:0] with zeros above. Any index above 3 reads as 0xFAFAFAFA.
- R8: A synchronous reset clears all four status bits and zeroes the handler, return-address and cause registers.
- R9: In the cycle a trap or interrupt is taken, trap_take is 1 and trap_target carries the handler address as left by the instruction step. trap_is_irq is 1 only when the device interrupt step fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_bubble | input | 1 | Memory-stage slot holds a flushed bubble |
| m_reti | input | 1 | Memory-stage return-from-interrupt |
| m_wsr | input | 1 | Memory-stage system-register write |
| m_sidx | input | 4 | Index of the register written |
| m_wdata | input | 32 | Write data |
| m_pcsave | input | 32 | Next PC of the memory-stage instruction |
| a_illegal | input | 1 | Illegal instruction in the ALU stage |
| irq_req | input | 1 | Device interrupt request pending |
| irq_dev | input | 4 | Number of the requesting device |
| rd_idx | input | 4 | Read-port index |
| rd_data | output | 32 | Read-port data |
| trap_take | output | 1 | A trap or interrupt is taken this cycle |
| trap_is_irq | output | 1 | The trap taken is a device interrupt |
| trap_target | output | 32 | Handler address to redirect fetch to |

## Verification
The assertions assume that the pipeline never presents a system-register write or a return-from-interrupt in a slot marked as a bubble, because the flush logic upstream has already cleared those controls. They also assume that reset is held for at least one clock edge at start-up. The directed tasks hold m_wsr and m_reti low whenever m_bubble is high. Each task also returns every input to idle before its last check.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int SRU_IDX_W = 4;

  localparam logic [SRU_IDX_W-1:0] IDX_STAT  = 4'd0;
  localparam logic [SRU_IDX_W-1:0] IDX_HAND  = 4'd1;
  localparam logic [SRU_IDX_W-1:0] IDX_RET   = 4'd2;
  localparam logic [SRU_IDX_W-1:0] IDX_CAUSE = 4'd3;

  typedef struct packed {
    logic om;
    logic cm;
    logic oie;
    logic ie;
  } sru_stat_t;
endpackage

// File: rtl/sru_inst_step.sv
module sru_inst_step
  import sru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  sru_stat_t                stat_in,
  input  logic [XLEN-1:0]          ha_in,
  input  logic [XLEN-1:0]          ra_in,
  input  logic                     reti,
  input  logic                     wsr,
  input  logic [SRU_IDX_W-1:0]     idx,
  input  logic [XLEN-1:0]          wdata,
  output sru_stat_t                stat_out,
  output logic [XLEN-1:0]          ha_out,
  output logic [XLEN-1:0]          ra_out
);
  always_comb begin
    stat_out = stat_in;
    ha_out   = ha_in;
    ra_out   = ra_in;
    if (reti) begin
      stat_out.ie = stat_in.oie;
      stat_out.cm = stat_in.om;
    end else if (wsr) begin
      case (idx)
        IDX_STAT: stat_out = sru_stat_t'(wdata[3:0]);
        IDX_HAND: ha_out   = wdata;
        IDX_RET:  ra_out   = wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sru_trap_step.sv
module sru_trap_step
  import sru_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              DEV_W     = 4,
  parameter logic [XLEN-1:0] ILL_CAUSE = 32'h0000_0100
) (
  input  sru_stat_t        stat_in,
  input  logic [XLEN-1:0]  ra_in,
  input  logic [XLEN-1:0]  cause_in,
  input  logic             illegal,
  input  logic             irq_req,
  input  logic [DEV_W-1:0] dev,
  input  logic             bubble,
  input  logic [XLEN-1:0]  pcsave,
  output sru_stat_t        stat_out,
  output logic [XLEN-1:0]  ra_out,
  output logic [XLEN-1:0]  cause_out,
  output logic             take_ill,
  output logic             take_dev
);
  sru_stat_t       st_ill;
  logic [XLEN-1:0] ra_ill;
  logic [XLEN-1:0] cause_ill;
  logic [XLEN-1:0] dev_ext;

  always_comb begin
    dev_ext = '0;
    dev_ext[DEV_W-1:0] = dev;
  end

  // illegal-instruction step
  always_comb begin
    st_ill    = stat_in;
    ra_ill    = ra_in;
    cause_ill = cause_in;
    take_ill  = 1'b0;
    if (illegal) begin
      take_ill   = 1'b1;
      st_ill.om  = stat_in.cm;
      st_ill.cm  = 1'b1;
      st_ill.oie = stat_in.ie;
      st_ill.ie  = 1'b0;
      ra_ill     = pcsave;
      cause_ill  = ILL_CAUSE;
    end
  end

  // device-interrupt step, sees the illegal step's result
  always_comb begin
    stat_out  = st_ill;
    ra_out    = ra_ill;
    cause_out = cause_ill;
    take_dev  = 1'b0;
    if (st_ill.ie && irq_req && !bubble) begin
      take_dev     = 1'b1;
      stat_out.om  = st_ill.cm;
      stat_out.cm  = 1'b1;
      stat_out.oie = st_ill.ie;
      stat_out.ie  = 1'b0;
      ra_out       = pcsave;
      cause_out    = dev_ext;
    end
  end
endmodule

// File: rtl/sru_rd_mux.sv
module sru_rd_mux
  import sru_pkg::*;
#(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] FILL = 32'hFAFA_FAFA
) (
  input  logic [SRU_IDX_W-1:0] idx,
  input  sru_stat_t            stat,
  input  logic [XLEN-1:0]      ha,
  input  logic [XLEN-1:0]      ra,
  input  logic [XLEN-1:0]      cause,
  output logic [XLEN-1:0]      dout
);
  always_comb begin
    case (idx)
      IDX_STAT: begin
        dout      = '0;
        dout[3:0] = stat;
      end
      IDX_HAND:  dout = ha;
      IDX_RET:   dout = ra;
      IDX_CAUSE: dout = cause;
      default:   dout = FILL;
    endcase
  end
endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              DEV_W     = 4,
  parameter logic [XLEN-1:0] ILL_CAUSE = 32'h0000_0100,
  parameter logic [XLEN-1:0] BAD_FILL  = 32'hFAFA_FAFA
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 m_bubble,
  input  logic                 m_reti,
  input  logic                 m_wsr,
  input  logic [SRU_IDX_W-1:0] m_sidx,
  input  logic [XLEN-1:0]      m_wdata,
  input  logic [XLEN-1:0]      m_pcsave,
  input  logic                 a_illegal,
  input  logic                 irq_req,
  input  logic [DEV_W-1:0]     irq_dev,
  input  logic [SRU_IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]      rd_data,
  output logic                 trap_take,
  output logic                 trap_is_irq,
  output logic [XLEN-1:0]      trap_target
);
  sru_stat_t       stat_q, stat_i, stat_n;
  logic [XLEN-1:0] ha_q, ha_i;
  logic [XLEN-1:0] ra_q, ra_i, ra_n;
  logic [XLEN-1:0] cause_q, cause_n;
  logic            take_ill, take_dev;

  sru_inst_step #(.XLEN(XLEN)) u_inst (
    .stat_in(stat_q), .ha_in(ha_q), .ra_in(ra_q),
    .reti(m_reti), .wsr(m_wsr), .idx(m_sidx), .wdata(m_wdata),
    .stat_out(stat_i), .ha_out(ha_i), .ra_out(ra_i)
  );

  sru_trap_step #(.XLEN(XLEN), .DEV_W(DEV_W), .ILL_CAUSE(ILL_CAUSE)) u_trap (
    .stat_in(stat_i), .ra_in(ra_i), .cause_in(cause_q),
    .illegal(a_illegal), .irq_req(irq_req), .dev(irq_dev),
    .bubble(m_bubble), .pcsave(m_pcsave),
    .stat_out(stat_n), .ra_out(ra_n), .cause_out(cause_n),
    .take_ill(take_ill), .take_dev(take_dev)
  );

  sru_rd_mux #(.XLEN(XLEN), .FILL(BAD_FILL)) u_rd (
    .idx(rd_idx), .stat(stat_q), .ha(ha_q), .ra(ra_q), .cause(cause_q),
    .dout(rd_data)
  );

  assign trap_take   = take_ill | take_dev;
  assign trap_is_irq = take_dev;
  assign trap_target = ha_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      ha_q    <= '0;
      ra_q    <= '0;
      cause_q <= '0;
    end else begin
      stat_q  <= stat_n;
      ha_q    <= ha_i;
      ra_q    <= ra_n;
      cause_q <= cause_n;
    end
  end
endmodule

// File: rtl/sru_chk.sv
module sru_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            m_bubble,
  input logic            m_reti,
  input logic            irq_req,
  input logic [XLEN-1:0] m_pcsave,
  input logic            trap_take,
  input logic            trap_is_irq,
  input logic [3:0]      stat,
  input logic [XLEN-1:0] ra,
  input logic [XLEN-1:0] ha,
  input logic [XLEN-1:0] cause,
  input logic [3:0]      rd_idx,
  input logic [XLEN-1:0] rd_data
);
  // R4: an interrupt needs a live slot and a pending request
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
    trap_is_irq |-> (irq_req && !m_bubble));

  // R9: an interrupt is one kind of trap
  p_irq_is_trap_r9: assert property (@(posedge clk) disable iff (rst)
    trap_is_irq |-> trap_take);

  // R5: any trap leaves interrupts disabled next cycle
  p_trap_clears_ie_r5: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (stat[0] == 1'b0 && stat[2] == 1'b1));

  // R5: the return address is the slot's own next PC
  p_trap_saves_pc_r5: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (ra == $past(m_pcsave)));

  // R1/R5: a device interrupt saves an enable that was set
  p_irq_saves_ie_r1: assert property (@(posedge clk) disable iff (rst)
    trap_is_irq |=> stat[1]);

  // R2: return restores the enable from the saved copy
  p_reti_restore_r2: assert property (@(posedge clk) disable iff (rst)
    (m_reti && !trap_take) |=> (stat[0] == $past(stat[1])));

  // R7: status reads are zero above bit 3
  p_stat_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 4'd0) |-> (rd_data[XLEN-1:4] == '0 && rd_data[3:0] == stat));

  // R8: reset clears the state
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (stat == 4'd0 && ra == '0 && ha == '0 && cause == '0));
endmodule

bind sru_top sru_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .m_bubble(m_bubble), .m_reti(m_reti),
  .irq_req(irq_req), .m_pcsave(m_pcsave), .trap_take(trap_take),
  .trap_is_irq(trap_is_irq), .stat(stat_q), .ra(ra_q), .ha(ha_q),
  .cause(cause_q), .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/sim_sru_top.sv
module sim_sru_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_bubble = 1'b0, m_reti = 1'b0, m_wsr = 1'b0;
  logic [3:0]  m_sidx = '0;
  logic [31:0] m_wdata = '0, m_pcsave = '0;
  logic        a_illegal = 1'b0, irq_req = 1'b0;
  logic [3:0]  irq_dev = '0, rd_idx = '0;
  logic [31:0] rd_data, trap_target;
  logic        trap_take, trap_is_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sru_top u0 (
    .clk(clk), .rst(rst), .m_bubble(m_bubble), .m_reti(m_reti),
    .m_wsr(m_wsr), .m_sidx(m_sidx), .m_wdata(m_wdata), .m_pcsave(m_pcsave),
    .a_illegal(a_illegal), .irq_req(irq_req), .irq_dev(irq_dev),
    .rd_idx(rd_idx), .rd_data(rd_data), .trap_take(trap_take),
    .trap_is_irq(trap_is_irq), .trap_target(trap_target)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    m_bubble = 0; m_reti = 0; m_wsr = 0; m_sidx = 0; m_wdata = 0;
    a_illegal = 0; irq_req = 0; irq_dev = 0;
  endtask

  // advance one edge, land mid-cycle
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] i, output logic [31:0] v);
    rd_idx = i;
    #0.5;
    v = rd_data;
  endtask

  task automatic wsr(input logic [3:0] i, input logic [31:0] d);
    m_wsr = 1; m_sidx = i; m_wdata = d;
    tick();
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R8 status", v, 32'h0);
    rd(1, v); chk("R8 handler", v, 32'h0);
    rd(2, v); chk("R8 return", v, 32'h0);
    rd(3, v); chk("R8 cause", v, 32'h0);
    rd(5, v); chk("R7 unknown idx 5", v, 32'hFAFAFAFA);
    rd(15, v); chk("R7 unknown idx 15", v, 32'hFAFAFAFA);
  endtask

  task automatic t_writes();
    logic [31:0] v;
    m_wsr = 1; m_sidx = 1; m_wdata = 32'h0000_1000;
    rd(1, v); chk("R7 start-of-cycle handler", v, 32'h0);
    tick(); idle();
    rd(1, v); chk("R3 handler write", v, 32'h0000_1000);
    wsr(2, 32'h0000_2222);
    rd(2, v); chk("R3 return write", v, 32'h0000_2222);
    wsr(3, 32'h0000_0055);
    rd(3, v); chk("R3 cause write ignored", v, 32'h0);
    wsr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R3/R7 status all ones", v, 32'h0000_000F);
    wsr(0, 32'h0);
    rd(0, v); chk("R3 status cleared", v, 32'h0);
  endtask

  task automatic t_wsr_irq_same_cycle();
    logic [31:0] v;
    m_wsr = 1; m_sidx = 0; m_wdata = 32'h1;
    irq_req = 1; irq_dev = 4'd7; m_pcsave = 32'h300;
    #0.5;
    chk("R1 take same cycle", {31'b0, trap_take}, 32'h1);
    chk("R9 is irq", {31'b0, trap_is_irq}, 32'h1);
    chk("R9 target", trap_target, 32'h0000_1000);
    tick(); idle();
    rd(0, v); chk("R5 status after irq", v, 32'h6);
    rd(2, v); chk("R5 return addr", v, 32'h300);
    rd(3, v); chk("R5 cause dev", v, 32'h7);
  endtask

  task automatic t_reti();
    logic [31:0] v;
    m_reti = 1;
    tick(); idle();
    rd(0, v); chk("R2 reti restores", v, 32'h3);
  endtask

  task automatic t_bubble();
    logic [31:0] v;
    irq_req = 1; irq_dev = 4'd2; m_bubble = 1; m_pcsave = 32'h440;
    #0.5;
    chk("R4 no take behind bubble", {31'b0, trap_take}, 32'h0);
    tick();
    rd(0, v); chk("R4 status kept behind bubble", v, 32'h3);
    m_bubble = 0;
    #0.5;
    chk("R4 take after bubble", {31'b0, trap_is_irq}, 32'h1);
    tick(); idle();
    rd(0, v); chk("R5 status", v, 32'h6);
    rd(2, v); chk("R5 return", v, 32'h440);
    rd(3, v); chk("R5 cause", v, 32'h2);
  endtask

  task automatic t_ie_off();
    logic [31:0] v;
    irq_req = 1; irq_dev = 4'd9;
    #0.5;
    chk("R4 ie off no take", {31'b0, trap_take}, 32'h0);
    tick(); idle();
    rd(3, v); chk("R4 cause kept", v, 32'h2);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    wsr(0, 32'h1);
    a_illegal = 1; irq_req = 1; irq_dev = 4'd5; m_pcsave = 32'h500;
    #0.5;
    chk("R6 take", {31'b0, trap_take}, 32'h1);
    chk("R6 device blocked", {31'b0, trap_is_irq}, 32'h0);
    tick(); idle();
    rd(0, v); chk("R6 status", v, 32'h6);
    rd(2, v); chk("R6 return", v, 32'h500);
    rd(3, v); chk("R6 cause code", v, 32'h100);
  endtask

  task automatic t_reti_blocks();
    logic [31:0] v;
    wsr(0, 32'h1);
    m_reti = 1; irq_req = 1; irq_dev = 4'd4;
    #0.5;
    chk("R1 reti clears ie first", {31'b0, trap_take}, 32'h0);
    tick(); idle();
    rd(0, v); chk("R1/R2 status after reti", v, 32'h0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    t_reset();
    t_writes();
    t_wsr_irq_same_cycle();
    t_reti();
    t_bubble();
    t_ie_off();
    t_illegal();
    t_reti_blocks();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule